// File: doc/BRIEF.md
# Trigger-Mode Acquisition Controller

This block sequences acquisition and readout for a daisy chain of front-end chips on one detector plane. While acquisition is on, the chips record hits. Either an external trigger (single-event mode) or a full event memory in any chip (burst mode) stops acquisition. Once acquisition stops, the controller emits a one-cycle header, selects each chip in turn for a fixed number of serial readout cycles, and waits a fixed settling time. It then re-enables acquisition.

The header holds two values. The first is a timestamp: the number of clock cycles between the latest self-trigger of any chip and the moment acquisition stopped. The second is a running readout count. The controller models each chip's event memory with its own occupancy counter. In single-event mode, external triggers that arrive while a readout is in progress are refused and counted. Bunch-crossing counters in every chip are cleared together, and only when a run starts. A memory-full readout therefore never disturbs their alignment.

Top module: `trig_acq_ctrl`

## Requirements
- R1: After reset, `acq_on`, `rd_active`, `hdr_valid` and every `bcid_rst` bit are low, and `hdr_cnt` and `rej_count` are zero.
- R2: When `run_en` is high in the idle state, `acq_on` rises in the next cycle and all `N_CHIPS` bits of `bcid_rst` are high in that same cycle only. Dropping `run_en` while acquiring returns the block to idle in the next cycle.
- R3: With `mode_burst` = 0, a cycle of `ext_trig` while acquiring makes `acq_on` low in the next cycle, and `hdr_valid` is high for exactly that one cycle.
- R4: `hdr_ts` equals the number of clock cycles strictly between the last acquiring cycle in which any `chip_trig` bit was high and the cycle that stopped acquisition. It counts from 0 at each entry into acquisition and saturates at all ones.
- R5: `hdr_cnt` increases by one for every readout, and the first readout after reset carries 1.
- R6: From the cycle after the header, chips are read in index order 0 to `N_CHIPS`-1. Each chip is read for `READ_CYCLES` cycles, with `rd_active` high and `rd_chip` holding the index.
- R7: After the last chip, `RESTART_CYCLES` cycles pass with `acq_on` and `rd_active` low. Acquisition then resumes with `bcid_rst` kept low.
- R8: With `mode_burst` = 1, `ext_trig` neither stops acquisition nor changes `rej_count`. A chip that has recorded `EVT_DEPTH` events stops acquisition in the following cycle.
- R9: A chip's event count advances only on its `chip_trig` bit during acquisition. The count is cleared when that chip's readout ends.
- R10: With `mode_burst` = 0, every cycle in which `ext_trig` is high during the header, readout or restart phase adds one to `rej_count`. The count saturates at 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run enable; starting a run clears bunch-crossing counters |
| mode_burst | input | 1 | 0: externally triggered single event, 1: self-triggered burst |
| ext_trig | input | 1 | External trigger, one cycle per trigger |
| chip_trig | input | N_CHIPS | Per-chip self-trigger flags, one cycle per recorded event |
| acq_on | output | 1 | Acquisition enable to all chips |
| bcid_rst | output | N_CHIPS | Simultaneous bunch-crossing counter clear |
| hdr_valid | output | 1 | Header word valid (one cycle before readout) |
| hdr_ts | output | 24 | Header timestamp |
| hdr_cnt | output | 16 | Header readout count |
| rd_active | output | 1 | Serial readout in progress |
| rd_chip | output | CHIP_W | Index of the chip being read |
| rej_count | output | 16 | Saturating count of refused external triggers |

## Verification
An internal state error shows up at the ports within one cycle. If the controller stalls in, or skips, a readout phase, `rd_chip` holds still or jumps out of order, or `acq_on` returns early or late against the fixed `READ_CYCLES` and `RESTART_CYCLES` windows. If an occupancy counter keeps a stale value, the burst stop comes early or late, and the bench sees this because `acq_on` stays high or falls on the wrong cycle. If the timestamp counter has a wrong base, `hdr_ts` is off in the header cycle. If a stray bunch-crossing clear occurs on restart, `bcid_rst` is high on the first cycle of resumed acquisition.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int HDR_TS_W  = 24;
    localparam int HDR_CNT_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQ,
        ST_STOP,
        ST_READ,
        ST_RESTART
    } acq_state_e;

    typedef struct packed {
        logic [HDR_TS_W-1:0]  ts;
        logic [HDR_CNT_W-1:0] cnt;
    } acq_hdr_t;

    function automatic logic [HDR_TS_W-1:0] ts_sat_inc(input logic [HDR_TS_W-1:0] v);
        return (v == {HDR_TS_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/acq_occupancy.sv
module acq_occupancy #(
    parameter int N_CHIPS   = 18,
    parameter int EVT_DEPTH = 128
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               count_en,
    input  logic [N_CHIPS-1:0] chip_trig,
    input  logic [N_CHIPS-1:0] clr,
    output logic [N_CHIPS-1:0] full
);
    localparam int DEPTH_W = $clog2(EVT_DEPTH + 1);
    localparam logic [DEPTH_W-1:0] DEPTH_V = DEPTH_W'(EVT_DEPTH);

    for (genvar g = 0; g < N_CHIPS; g++) begin : g_chip
        logic [DEPTH_W-1:0] occ;

        always_ff @(posedge clk) begin
            if (rst || clr[g]) begin
                occ <= '0;
            end else if (count_en && chip_trig[g] && occ != DEPTH_V) begin
                occ <= occ + 1'b1;
            end
        end

        assign full[g] = (occ == DEPTH_V);
    end

endmodule

// File: rtl/acq_timestamp.sv
module acq_timestamp
    import acq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                hit,
    input  logic                capture,
    output logic [HDR_TS_W-1:0] ts_cap
);
    logic [HDR_TS_W-1:0] ts_cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || hit) begin
            ts_cnt <= '0;
        end else begin
            ts_cnt <= ts_sat_inc(ts_cnt);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ts_cap <= '0;
        end else if (capture) begin
            ts_cap <= ts_cnt;
        end
    end

endmodule

// File: rtl/acq_sat_counter.sv
module acq_sat_counter #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [WIDTH-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc && count != {WIDTH{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/trig_acq_ctrl.sv
module trig_acq_ctrl
    import acq_pkg::*;
#(
    parameter int N_CHIPS        = 18,
    parameter int EVT_DEPTH      = 128,
    parameter int READ_CYCLES    = 160,
    parameter int RESTART_CYCLES = 8,
    localparam int CHIP_W        = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_en,
    input  logic                 mode_burst,
    input  logic                 ext_trig,
    input  logic [N_CHIPS-1:0]   chip_trig,
    output logic                 acq_on,
    output logic [N_CHIPS-1:0]   bcid_rst,
    output logic                 hdr_valid,
    output logic [HDR_TS_W-1:0]  hdr_ts,
    output logic [HDR_CNT_W-1:0] hdr_cnt,
    output logic                 rd_active,
    output logic [CHIP_W-1:0]    rd_chip,
    output logic [HDR_CNT_W-1:0] rej_count
);
    localparam int CYC_W = (READ_CYCLES > 1) ? $clog2(READ_CYCLES) : 1;
    localparam int RS_W  = (RESTART_CYCLES > 1) ? $clog2(RESTART_CYCLES) : 1;
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(READ_CYCLES - 1);
    localparam logic [RS_W-1:0]   RS_LAST   = RS_W'(RESTART_CYCLES - 1);
    localparam logic [CHIP_W-1:0] CHIP_LAST = CHIP_W'(N_CHIPS - 1);

    acq_state_e          st;
    logic [CHIP_W-1:0]   chip_idx;
    logic [CYC_W-1:0]    bit_cyc;
    logic [RS_W-1:0]     rs_cyc;
    logic [HDR_CNT_W-1:0] trig_cnt;
    logic                bcid_q;

    logic [N_CHIPS-1:0]  full;
    logic [N_CHIPS-1:0]  clr;
    logic                any_full;
    logic                stop_cond;
    logic                go_stop;
    logic                chip_done;
    logic                rej_inc;
    logic [HDR_TS_W-1:0] ts_cap;
    acq_hdr_t            hdr;

    // Stop source depends on mode: external trigger or any full chip memory
    assign any_full  = |full;
    assign stop_cond = mode_burst ? any_full : ext_trig;
    assign go_stop   = (st == ST_ACQ) && run_en && stop_cond;
    assign chip_done = (st == ST_READ) && (bit_cyc == CYC_LAST);

    // Refused triggers: single-event mode, outside acquisition of an active cycle
    assign rej_inc = !mode_burst && ext_trig &&
                     ((st == ST_STOP) || (st == ST_READ) || (st == ST_RESTART));

    for (genvar g = 0; g < N_CHIPS; g++) begin : g_clr
        assign clr[g] = chip_done && (chip_idx == CHIP_W'(g));
    end

    acq_occupancy #(
        .N_CHIPS   (N_CHIPS),
        .EVT_DEPTH (EVT_DEPTH)
    ) u_occ (
        .clk       (clk),
        .rst       (rst),
        .count_en  (st == ST_ACQ),
        .chip_trig (chip_trig),
        .clr       (clr),
        .full      (full)
    );

    acq_timestamp u_ts (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_ACQ),
        .hit     (|chip_trig),
        .capture (go_stop),
        .ts_cap  (ts_cap)
    );

    acq_sat_counter #(
        .WIDTH (HDR_CNT_W)
    ) u_rej (
        .clk   (clk),
        .rst   (rst),
        .inc   (rej_inc),
        .count (rej_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            chip_idx <= '0;
            bit_cyc  <= '0;
            rs_cyc   <= '0;
            trig_cnt <= '0;
            bcid_q   <= 1'b0;
        end else begin
            // Counter clear only when a run starts, never on a restart
            bcid_q <= (st == ST_IDLE) && run_en;
            unique case (st)
                ST_IDLE: begin
                    if (run_en) st <= ST_ACQ;
                end
                ST_ACQ: begin
                    if (!run_en) begin
                        st <= ST_IDLE;
                    end else if (stop_cond) begin
                        st       <= ST_STOP;
                        trig_cnt <= trig_cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    st       <= ST_READ;
                    chip_idx <= '0;
                    bit_cyc  <= '0;
                end
                ST_READ: begin
                    if (bit_cyc == CYC_LAST) begin
                        bit_cyc <= '0;
                        if (chip_idx == CHIP_LAST) begin
                            st     <= ST_RESTART;
                            rs_cyc <= '0;
                        end else begin
                            chip_idx <= chip_idx + 1'b1;
                        end
                    end else begin
                        bit_cyc <= bit_cyc + 1'b1;
                    end
                end
                ST_RESTART: begin
                    if (rs_cyc == RS_LAST) begin
                        st <= run_en ? ST_ACQ : ST_IDLE;
                    end else begin
                        rs_cyc <= rs_cyc + 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign hdr.ts  = ts_cap;
    assign hdr.cnt = trig_cnt;

    assign acq_on    = (st == ST_ACQ);
    assign rd_active = (st == ST_READ);
    assign rd_chip   = chip_idx;
    assign hdr_valid = (st == ST_STOP);
    assign hdr_ts    = hdr.ts;
    assign hdr_cnt   = hdr.cnt;
    assign bcid_rst  = {N_CHIPS{bcid_q}};

endmodule

// File: rtl/acq_ctrl_checker.sv
module acq_ctrl_checker
    import acq_pkg::*;
#(
    parameter int N_CHIPS = 18,
    parameter int CHIP_W  = 5
) (
    input logic                 clk,
    input logic                 rst,
    input acq_state_e           st,
    input logic                 acq_on,
    input logic                 rd_active,
    input logic [CHIP_W-1:0]    rd_chip,
    input logic                 hdr_valid,
    input logic                 bcid0,
    input logic [HDR_CNT_W-1:0] rej_count
);
    // R2: the counter clear coincides with acquisition being on
    a_r2_bcid_with_acq: assert property (@(posedge clk) disable iff (rst)
        bcid0 |-> acq_on);

    // R7: the counter clear only follows the idle state, never a restart
    a_r7_bcid_from_idle: assert property (@(posedge clk) disable iff (rst)
        bcid0 |-> $past(st) == ST_IDLE);

    // R3: a header is only produced right after acquiring, for one cycle
    a_r3_hdr_after_acq: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |-> $past(acq_on));

    a_r3_hdr_single: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> !hdr_valid);

    // R6: readout begins with chip 0 right after the header
    a_r6_read_after_hdr: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> (rd_active && rd_chip == '0));

    a_r6_chip_range: assert property (@(posedge clk) disable iff (rst)
        rd_active |-> (int'(rd_chip) < N_CHIPS));

    a_r6_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(acq_on && rd_active));

    // R10: refused-trigger count moves up by at most one per cycle
    a_r10_rej_step: assert property (@(posedge clk) disable iff (rst)
        (rej_count == $past(rej_count)) || (rej_count == $past(rej_count) + 1'b1));

endmodule

bind trig_acq_ctrl acq_ctrl_checker #(
    .N_CHIPS (N_CHIPS),
    .CHIP_W  (CHIP_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (st),
    .acq_on    (acq_on),
    .rd_active (rd_active),
    .rd_chip   (rd_chip),
    .hdr_valid (hdr_valid),
    .bcid0     (bcid_rst[0]),
    .rej_count (rej_count)
);

// File: tb/trig_acq_ctrl_test.sv
`timescale 1ns/1ps
module trig_acq_ctrl_test;
    localparam int NC    = 3;
    localparam int DEPTH = 4;
    localparam int RC    = 8;
    localparam int RS    = 4;
    localparam int CW    = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          run_en = 1'b0;
    logic          mode_burst = 1'b0;
    logic          ext_trig = 1'b0;
    logic [NC-1:0] chip_trig = '0;
    logic          acq_on;
    logic [NC-1:0] bcid_rst;
    logic          hdr_valid;
    logic [23:0]   hdr_ts;
    logic [15:0]   hdr_cnt;
    logic          rd_active;
    logic [CW-1:0] rd_chip;
    logic [15:0]   rej_count;

    int n_checks = 0;
    int n_fail   = 0;
    int exp_cnt  = 0;
    int exp_rej  = 0;

    always #2 clk = ~clk;

    trig_acq_ctrl #(
        .N_CHIPS        (NC),
        .EVT_DEPTH      (DEPTH),
        .READ_CYCLES    (RC),
        .RESTART_CYCLES (RS)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .run_en     (run_en),
        .mode_burst (mode_burst),
        .ext_trig   (ext_trig),
        .chip_trig  (chip_trig),
        .acq_on     (acq_on),
        .bcid_rst   (bcid_rst),
        .hdr_valid  (hdr_valid),
        .hdr_ts     (hdr_ts),
        .hdr_cnt    (hdr_cnt),
        .rd_active  (rd_active),
        .rd_chip    (rd_chip),
        .rej_count  (rej_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) step;
        rst = 1'b0;
        step;
        chk(!acq_on, "R1", "acq_on", acq_on, 0);
        chk(!rd_active && !hdr_valid, "R1", "rd_active|hdr_valid", rd_active | hdr_valid, 0);
        chk(bcid_rst == '0, "R1", "bcid_rst", bcid_rst, 0);
        chk(hdr_cnt == 0 && rej_count == 0, "R1", "hdr_cnt+rej_count",
            hdr_cnt + rej_count, 0);
    endtask

    task automatic t_start;
        run_en = 1'b1;
        step;
        chk(acq_on, "R2", "acq_on after run_en", acq_on, 1);
        chk(bcid_rst == 3'b111, "R2", "bcid_rst at run start", bcid_rst, 7);
        step;
        chk(bcid_rst == '0 && acq_on, "R2", "bcid_rst one cycle", bcid_rst, 0);
    endtask

    // Entered at the negedge where the header cycle is visible
    task automatic readout_check(input int exp_ts, input int pulses);
        bit order_ok;
        bit rs_ok;
        exp_cnt++;
        chk(hdr_valid && !acq_on, "R3", "header cycle", hdr_valid, 1);
        chk(hdr_ts == 24'(exp_ts), "R4", "hdr_ts", hdr_ts, exp_ts);
        chk(hdr_cnt == 16'(exp_cnt), "R5", "hdr_cnt", hdr_cnt, exp_cnt);
        for (int c = 0; c < NC; c++) begin
            order_ok = 1'b1;
            for (int k = 0; k < RC; k++) begin
                ext_trig = (c == 0 && k < pulses);
                step;
                if (!(rd_active && rd_chip == CW'(c) && !hdr_valid && !acq_on))
                    order_ok = 1'b0;
            end
            chk(order_ok, "R6", $sformatf("chip %0d window", c), rd_chip, c);
        end
        ext_trig = 1'b0;
        rs_ok = 1'b1;
        for (int k = 0; k < RS; k++) begin
            step;
            if (acq_on || rd_active || bcid_rst != '0) rs_ok = 1'b0;
        end
        chk(rs_ok, "R7", "restart gap", acq_on, 0);
        step;
        chk(acq_on, "R7", "acquisition resumes", acq_on, 1);
        chk(bcid_rst == '0, "R7", "no bcid clear on restart", bcid_rst, 0);
    endtask

    task automatic t_single(input int gap, input int pulses);
        mode_burst = 1'b0;
        chip_trig  = 3'b001;
        step;
        chip_trig  = '0;
        repeat (gap) step;
        ext_trig = 1'b1;
        step;
        ext_trig = 1'b0;
        readout_check(gap, pulses);
        exp_rej += pulses;
        chk(rej_count == 16'(exp_rej), "R10", "rej_count", rej_count, exp_rej);
    endtask

    task automatic t_burst;
        mode_burst = 1'b1;
        ext_trig = 1'b1;
        repeat (3) step;
        ext_trig = 1'b0;
        step;
        chk(acq_on, "R8", "ext_trig ignored in burst", acq_on, 1);
        chk(rej_count == 16'(exp_rej), "R8", "rej_count unchanged", rej_count, exp_rej);
        for (int i = 0; i < DEPTH - 1; i++) begin
            chip_trig = 3'b110;
            step;
            chip_trig = '0;
            step;
        end
        chk(acq_on, "R8", "below depth keeps acquiring", acq_on, 1);
        chip_trig = 3'b010;
        step;
        chip_trig = '0;
        chk(acq_on, "R8", "full chip stops one cycle later", acq_on, 1);
        step;
        readout_check(0, 0);
        // occupancy cleared by readout
        for (int i = 0; i < DEPTH - 1; i++) begin
            chip_trig = 3'b110;
            step;
            chip_trig = '0;
            step;
        end
        step;
        chk(acq_on, "R9", "occupancy cleared by readout", acq_on, 1);
        // triggers in idle are not counted
        run_en = 1'b0;
        step;
        chk(!acq_on, "R2", "run_en low returns idle", acq_on, 0);
        for (int i = 0; i < 2; i++) begin
            chip_trig = 3'b010;
            step;
            chip_trig = '0;
            step;
        end
        run_en = 1'b1;
        step;
        chk(acq_on && bcid_rst == 3'b111, "R2", "bcid clear on re-start", bcid_rst, 7);
        step;
        step;
        chk(acq_on, "R9", "idle triggers not counted", acq_on, 1);
        chip_trig = 3'b010;
        step;
        chip_trig = '0;
        step;
        readout_check(0, 0);
    endtask

    task automatic t_saturate;
        int guard;
        mode_burst = 1'b0;
        ext_trig   = 1'b1;
        guard = 0;
        while (rej_count != 16'hFFFF && guard < 100000) begin
            step;
            guard++;
        end
        chk(rej_count == 16'hFFFF, "R10", "reaches maximum", rej_count, 65535);
        repeat (60) step;
        chk(rej_count == 16'hFFFF, "R10", "saturates", rej_count, 65535);
        ext_trig = 1'b0;
    endtask

    initial begin
        #(4 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual 0 expected 1");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        t_reset;
        t_start;
        t_single(5, 0);
        t_single(0, 3);
        t_single(12, 1);
        t_burst;
        mode_burst = 1'b0;
        t_single(2, 2);
        t_saturate;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule